// File: doc/BRIEF.md
# Double-Precision Multiplier with Tiled Significand Product

This block multiplies two IEEE-754 binary64 operands. Each operand is split into its sign, its 11-bit biased exponent and its 52-bit stored fraction. The hidden leading one is added to form a 53-bit significand. The full 106-bit significand product is built one narrow sub-product at a time. Each sub-product is a 24-bit by 17-bit multiply, shifted into place and added into an accumulator. The block then normalizes the product, rounds it to nearest with ties to even, and packs the result word.

A caller places both operands on the inputs and pulses `start` for one cycle. Twelve clock cycles later, plus one capture cycle and one packing cycle, `done` pulses for one cycle. The result word and its flags are valid in that cycle and stay valid until the next result appears. Overflow and underflow are reported as flags. Operands that are not finite normal numbers and not zero are reported through a separate flag instead of being computed.

Top module: `dp_tile_mul`

## Requirements
- R1: For two finite normal operands whose result stays in range, `result` is the binary64 product rounded to nearest-even. The significand product is taken over the 53-bit significands, with the hidden one at bit 52.
- R2: The result sign bit (bit 63) is the XOR of the two operand sign bits. This holds for every outcome except the invalid case.
- R3: The result exponent (bits 62:52) is expA + expB - 1023. It is one higher when the significand product reaches 2.0, that is, when bit 105 of the 106-bit product is set.
- R4: Rounding uses the bit just below the kept 52-bit fraction as the guard bit, and the OR of all lower bits as the sticky bit. An exact half rounds up only when the fraction's lowest bit is 1.
- R5: `done` is a one-cycle pulse. It is visible 13 rising edges after the edge that accepts `start`: one edge to capture the operands, twelve edges of sub-products, and one edge to pack the result.
- R6: A `start` pulse that arrives before the previous result's `done` is ignored. It produces no extra `done`, and the pending result is unchanged.
- R7: If the adjusted exponent is 2047 or more, `ovf` is 1 and `result` is a signed infinity (exponent field all ones, fraction 0).
- R8: If the adjusted exponent is 0 or less, `unf` is 1 and `result` is a signed zero.
- R9: If either operand is zero (exponent field and fraction both 0), `result` is a zero with the XOR sign, and `ovf` and `unf` stay 0.
- R10: An operand with exponent field 2047, or with exponent field 0 and a nonzero fraction, sets `inval`. In that case `result` is 64'h7FF8_0000_0000_0000 and `ovf` and `unf` are 0. This check takes priority over the zero case.
- R11: After reset, `result`, `done`, `ovf`, `unf` and `inval` are all 0. Between `done` pulses, `result` and the flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to multiply op_a by op_b |
| op_a | input | 64 | First binary64 operand, sampled with start |
| op_b | input | 64 | Second binary64 operand, sampled with start |
| result | output | 64 | Packed binary64 product |
| done | output | 1 | One-cycle pulse marking a new result |
| ovf | output | 1 | Exponent overflowed; result is signed infinity |
| unf | output | 1 | Exponent underflowed; result is signed zero |
| inval | output | 1 | An operand was infinity, NaN or denormal |

## Verification
The main product is tried with four kinds of input. Simple exact values such as 1x1 and -2x3 separate sign and exponent errors from significand errors. Products of 1.5 by 1.5 cross 2.0, which exposes a missing renormalization shift. Pairs built to land exactly on a half-ulp, one with an odd kept fraction and one with an even one, tell ties-to-even apart from plain round-half-up. Random operands with mixed exponents reach every one of the twelve sub-product tiles with nonzero bits, so a wrong shift or a dropped tile shows up. Exponents are pushed just onto and just off the 2047 and 0 limits, including a case rescued from underflow by the product-carry increment. Back-to-back requests and a request sent while busy check that requests are accepted and spaced correctly.

// File: rtl/dpm_pkg.sv
// Shared constants and operand type for the tiled binary64 multiplier.
// Assumes binary64 layout: sign at the top, then exponent, then fraction.
package dpm_pkg;
    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int WORD_W   = 1 + EXP_W + FRAC_W;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;
    localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int ESUM_W   = EXP_W + 2;
    localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // Decoded operand fields plus its class
    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [SIG_W-1:0] sig;
        logic             zero;
        logic             spec;
    } opnd_t;
endpackage

// File: rtl/dpm_unpack.sv
// Splits one binary64 word into sign, exponent and 53-bit significand.
// Also classifies the word as zero or special (inf/NaN/denormal).
// Assumes nothing about timing: purely combinational.
module dpm_unpack
    import dpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opnd_t             fields
);
    logic [EXP_W-1:0]  e_f;
    logic [FRAC_W-1:0] f_f;

    // Field split and classification
    always_comb begin
        e_f          = word[WORD_W-2 -: EXP_W];
        f_f          = word[FRAC_W-1:0];
        fields.sign  = word[WORD_W-1];
        fields.expo  = e_f;
        fields.sig   = {(e_f != '0), f_f};
        fields.zero  = (e_f == '0) && (f_f == '0);
        fields.spec  = (e_f == EXP_WIDTH_ONES()) || ((e_f == '0) && (f_f != '0));
    end

    function automatic logic [EXP_W-1:0] EXP_WIDTH_ONES();
        return {EXP_W{1'b1}};
    endfunction
endmodule

// File: rtl/dpm_tile_acc.sv
// Forms the full significand product one narrow tile per cycle.
// Operand A is cut into TILE_A_W-bit chunks and B into TILE_B_W-bit chunks.
// The short top chunks are zero-extended. Each chunk pair is multiplied,
// shifted by the sum of the chunks' bit offsets and added into the
// accumulator. Assumes load is ignored while busy.
module dpm_tile_acc
    import dpm_pkg::*;
#(
    parameter int TILE_A_W = 24,
    parameter int TILE_B_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic              busy,
    output logic              prod_valid,
    output logic [PROD_W-1:0] prod
);
    localparam int A_N  = (SIG_W + TILE_A_W - 1) / TILE_A_W;
    localparam int B_N  = (SIG_W + TILE_B_W - 1) / TILE_B_W;
    localparam int PW   = TILE_A_W + TILE_B_W;
    localparam int IA_W = $clog2(A_N + 1);
    localparam int JB_W = $clog2(B_N + 1);

    logic [SIG_W-1:0]    sa_q, sb_q;
    logic [PROD_W-1:0]   acc;
    logic [IA_W-1:0]     ia;
    logic [JB_W-1:0]     jb;
    logic                run, fin;
    logic [TILE_A_W-1:0] a_ch [A_N];
    logic [TILE_B_W-1:0] b_ch [B_N];
    logic [TILE_A_W-1:0] a_sel;
    logic [TILE_B_W-1:0] b_sel;
    logic [PW-1:0]       tile;
    logic [PROD_W-1:0]   tile_sh;
    logic                last;
    int                  off;

    // Chunk slicing of each significand
    for (genvar gi = 0; gi < A_N; gi++) begin : g_a_chunk
        assign a_ch[gi] = TILE_A_W'(sa_q >> (gi * TILE_A_W));
    end
    for (genvar gj = 0; gj < B_N; gj++) begin : g_b_chunk
        assign b_ch[gj] = TILE_B_W'(sb_q >> (gj * TILE_B_W));
    end

    // Current tile product and its placement
    always_comb begin
        a_sel   = a_ch[ia];
        b_sel   = b_ch[jb];
        tile    = PW'(a_sel) * PW'(b_sel);
        off     = int'(ia) * TILE_A_W + int'(jb) * TILE_B_W;
        tile_sh = PROD_W'(tile) << off;
        last    = (ia == IA_W'(A_N - 1)) && (jb == JB_W'(B_N - 1));
    end

    // Tile sequencing and accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q <= '0;
            sb_q <= '0;
            acc  <= '0;
            ia   <= '0;
            jb   <= '0;
            run  <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load && !busy) begin
                sa_q <= sig_a;
                sb_q <= sig_b;
                acc  <= '0;
                ia   <= '0;
                jb   <= '0;
                run  <= 1'b1;
            end else if (run) begin
                acc <= acc + tile_sh;
                if (jb == JB_W'(B_N - 1)) begin
                    jb <= '0;
                    ia <= ia + 1'b1;
                end else begin
                    jb <= jb + 1'b1;
                end
                if (last) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign busy       = run | fin;
    assign prod_valid = fin;
    assign prod       = acc;
endmodule

// File: rtl/dpm_round_pack.sv
// Normalizes the 106-bit product and rounds it to nearest-even.
// Applies exponent limits and packs the binary64 word.
// Priority: special operand, then zero operand, then overflow, then underflow.
// Combinational; esum is the exponent sum already reduced by the bias.
module dpm_round_pack
    import dpm_pkg::*;
(
    input  logic [PROD_W-1:0]        prod,
    input  logic signed [ESUM_W-1:0] esum,
    input  logic                     sign,
    input  logic                     zero,
    input  logic                     spec,
    output logic [WORD_W-1:0]        word,
    output logic                     ovf,
    output logic                     unf
);
    logic              hi, guard, sticky, rnd_up;
    logic [FRAC_W-1:0] mant;
    logic [FRAC_W:0]   mant_r;
    int                e_int;

    // Normalize, round, limit and pack
    always_comb begin
        hi = prod[PROD_W-1];
        if (hi) begin
            mant   = prod[PROD_W-2 -: FRAC_W];
            guard  = prod[PROD_W-2-FRAC_W];
            sticky = |prod[PROD_W-3-FRAC_W:0];
        end else begin
            mant   = prod[PROD_W-3 -: FRAC_W];
            guard  = prod[PROD_W-3-FRAC_W];
            sticky = |prod[PROD_W-4-FRAC_W:0];
        end
        rnd_up = guard & (sticky | mant[0]);
        mant_r = {1'b0, mant} + (FRAC_W+1)'(rnd_up);
        e_int  = int'(esum) + int'(hi) + int'(mant_r[FRAC_W]);
        ovf    = 1'b0;
        unf    = 1'b0;
        if (spec) begin
            word = QNAN_WORD;
        end else if (zero) begin
            word = {sign, {(WORD_W-1){1'b0}}};
        end else if (e_int >= EXP_MAX) begin
            ovf  = 1'b1;
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (e_int <= 0) begin
            unf  = 1'b1;
            word = {sign, {(WORD_W-1){1'b0}}};
        end else begin
            word = {sign, EXP_W'(e_int), mant_r[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/dp_tile_mul.sv
// Top of the tiled binary64 multiplier. It accepts a start pulse when idle,
// latches the sign, the exponent sum and the operand class, drives the tile
// accumulator, and registers the packed result with a one-cycle done pulse.
// Assumes the caller holds op_a/op_b valid in the start cycle only.
module dp_tile_mul
    import dpm_pkg::*;
#(
    parameter int TILE_A_W = 24,
    parameter int TILE_B_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] result,
    output logic              done,
    output logic              ovf,
    output logic              unf,
    output logic              inval
);
    opnd_t                     fa, fb;
    logic                      busy, prod_valid, accept;
    logic [PROD_W-1:0]         prod;
    logic                      sign_q, zero_q, spec_q;
    logic signed [ESUM_W-1:0]  esum_q, esum_d;
    logic [WORD_W-1:0]         pk_word;
    logic                      pk_ovf, pk_unf;

    dpm_unpack u_unp_a (.word(op_a), .fields(fa));
    dpm_unpack u_unp_b (.word(op_b), .fields(fb));

    dpm_tile_acc #(.TILE_A_W(TILE_A_W), .TILE_B_W(TILE_B_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .sig_a     (fa.sig),
        .sig_b     (fb.sig),
        .busy      (busy),
        .prod_valid(prod_valid),
        .prod      (prod)
    );

    dpm_round_pack u_pack (
        .prod(prod),
        .esum(esum_q),
        .sign(sign_q),
        .zero(zero_q),
        .spec(spec_q),
        .word(pk_word),
        .ovf (pk_ovf),
        .unf (pk_unf)
    );

    // Request acceptance and biased exponent sum
    always_comb begin
        accept = start && !busy;
        esum_d = ESUM_W'(int'(fa.expo) + int'(fb.expo) - EXP_BIAS);
    end

    // Per-request side information capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
            zero_q <= 1'b0;
            spec_q <= 1'b0;
            esum_q <= '0;
        end else if (accept) begin
            sign_q <= fa.sign ^ fb.sign;
            zero_q <= fa.zero | fb.zero;
            spec_q <= fa.spec | fb.spec;
            esum_q <= esum_d;
        end
    end

    // Output registers, updated only when a product completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
            inval  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= prod_valid;
            if (prod_valid) begin
                result <= pk_word;
                ovf    <= pk_ovf;
                unf    <= pk_unf;
                inval  <= spec_q;
            end
        end
    end
endmodule

// File: rtl/dp_tile_mul_chk.sv
// Property checker for dp_tile_mul, attached by bind. It tracks accepted
// requests with its own counter so the done window needs no deep delay.
module dp_tile_mul_chk
    import dpm_pkg::*;
#(
    parameter int TILE_A_W = 24,
    parameter int TILE_B_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] result,
    input logic              done,
    input logic              ovf,
    input logic              unf,
    input logic              inval
);
    localparam int LAT   = ((SIG_W + TILE_A_W - 1) / TILE_A_W) * ((SIG_W + TILE_B_W - 1) / TILE_B_W) + 1;
    localparam int CYC_W = $clog2(LAT + 1);

    logic             pend;
    logic [CYC_W-1:0] cyc;
    logic             at_lat;

    assign at_lat = pend && (cyc == CYC_W'(LAT));

    // Independent model of request occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            cyc  <= '0;
        end else if (start && (!pend || at_lat)) begin
            pend <= 1'b1;
            cyc  <= '0;
        end else if (at_lat) begin
            pend <= 1'b0;
        end else if (pend) begin
            cyc <= cyc + 1'b1;
        end
    end

    // R5
    done_due_chk: assert property (@(posedge clk) disable iff (!rst_n) at_lat |-> done);
    // R5
    done_only_when_due_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> at_lat);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R7
    ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
    // R8
    unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unf) |-> (result[WORD_W-2:0] == '0));
    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ovf && unf));
    // R10
    inval_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && inval) |-> (result == QNAN_WORD && !ovf && !unf));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done || ($stable(result) && $stable(ovf) && $stable(unf) && $stable(inval)));
endmodule

bind dp_tile_mul dp_tile_mul_chk #(.TILE_A_W(TILE_A_W), .TILE_B_W(TILE_B_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .result(result),
    .done  (done),
    .ovf   (ovf),
    .unf   (unf),
    .inval (inval)
);

// File: tb/dp_tile_mul_test.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops them on done.
module dp_tile_mul_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [63:0] result;
    logic        done, ovf, unf, inval;

    typedef struct {
        logic [63:0] res;
        logic        ovf, unf, inval;
        int          issue;
        string       tag;
    } item_t;

    item_t       sbq[$];
    int          checks = 0, fails = 0, cyc = 0;
    logic [63:0] last_res = '0;
    bit          mon_on = 1'b0;

    dp_tile_mul uut (.clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
                     .result(result), .done(done), .ovf(ovf), .unf(unf), .inval(inval));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Requirement-based reference product
    function automatic item_t model(logic [63:0] a, logic [63:0] b);
        item_t       it;
        logic [105:0] p;
        logic [51:0]  m;
        logic [52:0]  mr;
        logic         g, st, s;
        int           e;
        it.ovf = 0; it.unf = 0; it.inval = 0;
        s = a[63] ^ b[63];
        if (a[62:52] == 11'h7FF || (a[62:52] == 0 && a[51:0] != 0) ||
            b[62:52] == 11'h7FF || (b[62:52] == 0 && b[51:0] != 0)) begin
            it.inval = 1; it.res = 64'h7FF8_0000_0000_0000; return it;
        end
        if (a[62:0] == 0 || b[62:0] == 0) begin
            it.res = {s, 63'd0}; return it;
        end
        p = {53'd0, 1'b1, a[51:0]} * {53'd0, 1'b1, b[51:0]};
        e = int'(a[62:52]) + int'(b[62:52]) - 1023;
        if (p[105]) begin m = p[104:53]; g = p[52]; st = |p[51:0]; e++; end
        else begin m = p[103:52]; g = p[51]; st = |p[50:0]; end
        mr = {1'b0, m} + 53'(g & (st | m[0]));
        if (mr[52]) e++;
        if (e >= 2047) begin it.ovf = 1; it.res = {s, 11'h7FF, 52'd0}; end
        else if (e <= 0) begin it.unf = 1; it.res = {s, 63'd0}; end
        else it.res = {s, 11'(e), mr[51:0]};
        return it;
    endfunction

    // Driver: one request, optionally without waiting for a fresh negedge
    task automatic send(logic [63:0] a, logic [63:0] b, bit use_k, logic [63:0] kres,
                        string tag, bit now);
        item_t it;
        if (!now) @(negedge clk);
        it = model(a, b);
        if (use_k) begin
            chk(it.res == kres, tag, "reference value", it.res, kres);
            it.res = kres;
        end
        it.issue = cyc;
        it.tag   = tag;
        op_a = a; op_b = b; start = 1'b1;
        sbq.push_back(it);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic run(logic [63:0] a, logic [63:0] b, string tag);
        send(a, b, 0, 64'd0, tag, 0);
        wait_done();
    endtask

    task automatic run_k(logic [63:0] a, logic [63:0] b, logic [63:0] k, string tag);
        send(a, b, 1, k, tag, 0);
        wait_done();
    endtask

    // Monitor: pops and compares on done, checks holding otherwise
    always @(negedge clk) begin
        if (mon_on) begin
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(0, "R6", "unexpected done", 64'd1, 64'd0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk(result == it.res, it.tag, "result", result, it.res);
                    chk({ovf, unf, inval} == {it.ovf, it.unf, it.inval}, it.tag, "flags ovf/unf/inval",
                        64'({ovf, unf, inval}), 64'({it.ovf, it.unf, it.inval}));
                    chk(cyc == it.issue + 14, "R5", "done latency", 64'(cyc - it.issue), 64'd14);
                end
                last_res = result;
            end else if (result != last_res) begin
                chk(0, "R11", "result changed without done", result, last_res);
            end
        end
    end

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(result == 0 && !done && !ovf && !unf && !inval, "R11", "reset outputs",
            {result[59:0], done, ovf, unf, inval}, 64'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        run_k(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R1 one*one");
        run_k(64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0000, 64'h4002_0000_0000_0000, "R3 carry 1.5*1.5");
        run_k(64'hC000_0000_0000_0000, 64'h4008_0000_0000_0000, 64'hC018_0000_0000_0000, "R2 -2*3");
        run_k(64'hC000_0000_0000_0000, 64'hC008_0000_0000_0000, 64'h4018_0000_0000_0000, "R2 -2*-3");
        run_k(64'h3FF0_0000_0000_0001, 64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0002, "R4 tie odd up");
        run_k(64'h3FF0_0000_0000_0003, 64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0004, "R4 tie even stay");
        run_k(64'h3FFF_FFFF_FFFF_FFFF, 64'h3FFF_FFFF_FFFF_FFFF, 64'h400F_FFFF_FFFF_FFFE, "R4 sticky below half");
        run_k(64'h7FE0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h7FF0_0000_0000_0000, "R7 exp 2047");
        run_k(64'hFFE0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'hFFF0_0000_0000_0000, "R7 neg overflow");
        run_k(64'h7FE0_0000_0000_0000, 64'h3FF8_0000_0000_0000, 64'h7FE8_0000_0000_0000, "R7 exp 2046 ok");
        run_k(64'h0010_0000_0000_0000, 64'h3FE0_0000_0000_0000, 64'h0000_0000_0000_0000, "R8 exp 0");
        run_k(64'h8010_0000_0000_0000, 64'h3FE0_0000_0000_0000, 64'h8000_0000_0000_0000, "R8 neg underflow");
        run_k(64'h0010_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h0010_0000_0000_0000, "R8 exp 1 ok");
        run_k(64'h0018_0000_0000_0000, 64'h3FE8_0000_0000_0000, 64'h0012_0000_0000_0000, "R3 carry avoids underflow");
        run_k(64'h0000_0000_0000_0000, 64'hC014_0000_0000_0000, 64'h8000_0000_0000_0000, "R9 +0*-5");
        run_k(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, "R9 -0*-0");
        run_k(64'h0000_0000_0000_0000, 64'h7FE0_0000_0000_0000, 64'h0000_0000_0000_0000, "R9 zero no ovf");
        run_k(64'h7FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_0000, "R10 inf");
        run_k(64'h3FF0_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h7FF8_0000_0000_0000, "R10 denormal");
        run_k(64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h7FF8_0000_0000_0000, "R10 inf*0 priority");

        // R6: second start while busy is ignored
        send(64'h4008_0000_0000_0000, 64'h4014_0000_0000_0000, 1, 64'h402E_0000_0000_0000, "R6 first kept", 0);
        repeat (3) @(negedge clk);
        op_a = 64'h4000_0000_0000_0000; op_b = 64'h4000_0000_0000_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);

        // R5: back-to-back request issued in the done cycle
        send(64'h3FF8_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 64'd0, "R5 b2b first", 0);
        wait_done();
        send(64'h4010_0000_0000_0000, 64'hBFE0_0000_0000_0000, 0, 64'd0, "R5 b2b second", 1);
        wait_done();

        // R1: random normal operands across all tiles
        for (int i = 0; i < 60; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            a[62:52] = 11'(900 + ($urandom % 250));
            b[62:52] = 11'(900 + ($urandom % 250));
            if (i % 10 == 0) a[62:52] = 11'(1 + ($urandom % 60));
            if (i % 10 == 5) b[62:52] = 11'(2000 + ($urandom % 46));
            run(a, b, "R1 random");
        end

        repeat (5) @(negedge clk);
        chk(sbq.size() == 0, "R6", "scoreboard drained", 64'(sbq.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule